// File: doc/BRIEF.md
# Masked ADC Input Scan Sequencer

This block steps an analog-to-digital converter through a chosen set of positive input channels. Software writes a channel enable mask into a single register, one bit per channel. On a start trigger the sequencer selects the lowest enabled channel, then issues a conversion start. Each time the converter signals that it has finished, the sequencer moves on to the next higher enabled channel. Channels whose bits are clear are skipped without any software action.

The next channel is found combinationally. The search discards the current position and everything below it, then takes the lowest remaining enabled bit. When no enabled channel lies above the one just converted, the sequencer emits a one-cycle completion pulse and goes idle. The mask register can be read back at any time. Writes to it are ignored while the write-protect input is high. A write made during a scan is honoured from the next channel search onward.

All pins are plain control and status signals. Nothing here carries a data stream, so there is no valid/ready handshake and no back-pressure. The select output is meaningful from the start pulse until the matching done input.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the mask reads back as all zeros, busy, conv_start and seq_done are low, and reg_rd_data always shows the current mask.
- R2: A write with reg_wr_en high and reg_wr_lock low loads reg_wr_data into the mask, and the new value is visible on reg_rd_data from the next cycle. Bit n set means channel n is part of the scan.
- R3: While reg_wr_lock is high, a write leaves the mask unchanged.
- R4: A trigger sampled while idle with a non-zero mask makes mux_sel equal the lowest set mask bit in the next cycle, with busy and conv_start high in that same cycle.
- R5: A conv_done sampled while waiting on a conversion moves mux_sel to the next higher enabled channel in the following cycle, with conv_start high, skipping clear bits. Channels are converted strictly in ascending order.
- R6: A trigger while the mask is all zeros selects no channel, raises neither busy nor conv_start, and produces no seq_done.
- R7: After conv_done for the highest enabled channel, seq_done is high for exactly one cycle, busy is low in that cycle, and the block stays idle until the next trigger.
- R8: A trigger sampled while busy has no effect on the channel order or on the end of the scan.
- R9: A conv_done sampled in the cycle conv_start is high (before the converter is waiting) is ignored: mux_sel does not change and no new start is issued.
- R10: A mask write during a scan takes effect at the next channel search. A write of all zeros ends the scan, with seq_done, after the conversion in flight.
- R11: conv_start is never high for two consecutive cycles, and mux_sel changes only on an advance out of idle or out of a finished conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Mask register write strobe |
| reg_wr_lock | input | 1 | Write protect; blocks mask writes when high |
| reg_wr_data | input | NCH (32) | Mask write value |
| reg_rd_data | output | NCH (32) | Current mask |
| trigger | input | 1 | Start a scan (honoured only when idle) |
| conv_done | input | 1 | Converter finished the current conversion |
| mux_sel | output | $clog2(NCH) (5) | Positive input mux select |
| conv_start | output | 1 | One-cycle conversion start request |
| busy | output | 1 | Scan in progress |
| seq_done | output | 1 | One-cycle scan complete pulse |

## Verification
The assertions take for granted that the converter answers each start with a single-cycle conv_done, arriving at least one cycle after conv_start. They also assume trigger and mask writes are synchronous single-cycle strobes. The channel-enabled property excuses the cycle that follows a mask write, because such a write may clear a bit that was just selected. The stimulus keeps within these limits by using a converter model that raises conv_done for exactly one cycle, three cycles after each start. All trigger and write pulses are driven one cycle wide between clock edges. The only deliberate early done is the one used to show that the block ignores it.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/scan_mask_reg.sv
module scan_mask_reg #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_lock,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      mask <= '0;
    else if (wr_en && !wr_lock)
      mask <= wr_data;
  end
endmodule

// File: rtl/scan_next_pick.sv
module scan_next_pick #(
  parameter int NCH = 32,
  localparam int SW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [SW-1:0]  cur,
  input  logic           from_bottom,
  output logic           found,
  output logic [SW-1:0]  idx
);
  logic [NCH-1:0] elig;

  // keep only positions strictly above the current one (or all, from bottom)
  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = mask[g] & (from_bottom | (SW'(g) > cur));
  end

  // priority encoder: lowest eligible bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int NCH = 32,
  localparam int SW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  input  logic          conv_done,
  input  logic          found,
  input  logic [SW-1:0] idx,
  output logic          from_bottom,
  output logic [SW-1:0] sel,
  output logic          conv_start,
  output logic          busy,
  output logic          seq_done
);
  scan_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel      <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trigger && found) begin
            sel   <= idx;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (conv_done) begin
            if (found) begin
              sel   <= idx;
              state <= ST_ISSUE;
            end else begin
              state    <= ST_IDLE;
              seq_done <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign from_bottom = (state == ST_IDLE);
  assign conv_start  = (state == ST_ISSUE);
  assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH = 32,
  localparam int SW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic           reg_wr_lock,
  input  logic [NCH-1:0] reg_wr_data,
  output logic [NCH-1:0] reg_rd_data,
  input  logic           trigger,
  input  logic           conv_done,
  output logic [SW-1:0]  mux_sel,
  output logic           conv_start,
  output logic           busy,
  output logic           seq_done
);
  logic [NCH-1:0] mask;
  logic           found;
  logic [SW-1:0]  idx;
  logic           from_bottom;

  scan_mask_reg #(.NCH(NCH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_lock (reg_wr_lock),
    .wr_data (reg_wr_data),
    .mask    (mask)
  );

  scan_next_pick #(.NCH(NCH)) u_pick (
    .mask        (mask),
    .cur         (mux_sel),
    .from_bottom (from_bottom),
    .found       (found),
    .idx         (idx)
  );

  scan_ctrl #(.NCH(NCH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .trigger     (trigger),
    .conv_done   (conv_done),
    .found       (found),
    .idx         (idx),
    .from_bottom (from_bottom),
    .sel         (mux_sel),
    .conv_start  (conv_start),
    .busy        (busy),
    .seq_done    (seq_done)
  );

  assign reg_rd_data = mask;
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int NCH = 32,
  localparam int SW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr_en,
  input logic           reg_wr_lock,
  input logic [NCH-1:0] reg_wr_data,
  input logic [NCH-1:0] reg_rd_data,
  input logic           trigger,
  input logic           conv_done,
  input logic [SW-1:0]  mux_sel,
  input logic           conv_start,
  input logic           busy,
  input logic           seq_done
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_lock) |=> (reg_rd_data == $past(reg_wr_data))); // R2

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_lock |=> $stable(reg_rd_data)); // R3

  AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !$past(reg_wr_en && !reg_wr_lock)) |-> reg_rd_data[mux_sel]); // R4

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(busy)) |-> (mux_sel > $past(mux_sel))); // R5

  AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trigger && reg_rd_data == '0) |=> !busy); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R7

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(!busy && trigger) || $past(busy && conv_done))); // R9

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R11

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> $stable(mux_sel)); // R11
endmodule

bind adc_scan_seq scan_checker #(.NCH(NCH)) u_scan_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_lock (reg_wr_lock),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .trigger     (trigger),
  .conv_done   (conv_done),
  .mux_sel     (mux_sel),
  .conv_start  (conv_start),
  .busy        (busy),
  .seq_done    (seq_done)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int SW = $clog2(NCH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr_en = 1'b0;
  logic           reg_wr_lock = 1'b0;
  logic [NCH-1:0] reg_wr_data = '0;
  logic [NCH-1:0] reg_rd_data;
  logic           trigger = 1'b0;
  logic           conv_done;
  logic [SW-1:0]  mux_sel;
  logic           conv_start;
  logic           busy;
  logic           seq_done;

  logic auto_on = 1'b0;
  logic auto_done = 1'b0;
  logic man_done = 1'b0;
  int   cd_cnt = 0;
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  logic prev_start = 1'b0;
  int   exp_q[$];

  assign conv_done = auto_done | man_done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_scan_seq #(.NCH(NCH)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_lock (reg_wr_lock),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .trigger     (trigger),
    .conv_done   (conv_done),
    .mux_sel     (mux_sel),
    .conv_start  (conv_start),
    .busy        (busy),
    .seq_done    (seq_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // converter model: one-cycle done three cycles after each start
  always @(negedge clk) begin
    auto_done = 1'b0;
    if (auto_on) begin
      if (cd_cnt > 0) begin
        cd_cnt--;
        if (cd_cnt == 0) auto_done = 1'b1;
      end
      if (conv_start) cd_cnt = 3;
    end else begin
      cd_cnt = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start) begin
        chk(!prev_start, "R11 start width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected start", longint'(mux_sel), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(mux_sel == SW'(e), "R4/R5 channel order", longint'(mux_sel), e);
        end
      end
      prev_start = conv_start;
    end
  end

  task automatic summary_and_end();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected < 50000 cycles", cyc);
      summary_and_end();
    end
  end

  task automatic wr(input logic [NCH-1:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic push_mask(input logic [NCH-1:0] m);
    for (int i = 0; i < NCH; i++)
      if (m[i]) exp_q.push_back(i);
  endtask

  task automatic wait_done(input string tag);
    while (!seq_done) @(negedge clk);
    chk(!busy, {tag, " R7 busy low at done"}, busy, 0);
    chk(exp_q.size() == 0, {tag, " R5 all channels converted"}, exp_q.size(), 0);
    @(negedge clk);
    chk(!seq_done, {tag, " R7 done one cycle"}, seq_done, 0);
    chk(!busy, {tag, " R7 stays idle"}, busy, 0);
  endtask

  task automatic run_scan(input logic [NCH-1:0] m, input string tag);
    wr(m);
    chk(reg_rd_data == m, {tag, " R2 mask readback"}, reg_rd_data, m);
    push_mask(m);
    pulse_trig();
    chk(busy && conv_start, {tag, " R4 busy+start after trigger"}, {busy, conv_start}, 3);
    wait_done(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rd_data == '0, "R1 mask reset", reg_rd_data, 0);
    chk(!busy && !conv_start && !seq_done, "R1 outputs idle", {busy, conv_start, seq_done}, 0);

    // R6: empty mask
    pulse_trig();
    chk(!busy && !conv_start, "R6 empty trigger", {busy, conv_start}, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !seq_done, "R6 stays idle", {busy, seq_done}, 0);

    // R3: write protection
    reg_wr_lock = 1'b1;
    wr(32'hDEAD_BEEF);
    chk(reg_rd_data == '0, "R3 locked write ignored", reg_rd_data, 0);
    reg_wr_lock = 1'b0;

    auto_on = 1'b1;
    run_scan(32'h0000_0001, "single0");
    run_scan(32'h8000_0000, "single31");
    run_scan(32'h8000_0001, "ends");
    run_scan(32'h0042_10A5, "sparse");
    run_scan(32'hFFFF_FFFF, "full");

    // R8: retrigger while busy
    wr(32'h0000_0F00);
    push_mask(32'h0000_0F00);
    pulse_trig();
    pulse_trig();
    chk(busy, "R8 busy during retrigger", busy, 1);
    wait_done("retrig R8");

    // R10: mask change during scan
    wr(32'h0000_00F0);
    exp_q.push_back(4);
    exp_q.push_back(28);
    pulse_trig();
    wr(32'h1000_0010);
    wait_done("remask R10");

    wr(32'h0000_000F);
    exp_q.push_back(0);
    pulse_trig();
    wr(32'h0000_0000);
    wait_done("clear R10");
    chk(reg_rd_data == '0, "R10 cleared mask", reg_rd_data, 0);

    // R9: early done ignored
    auto_on = 1'b0;
    repeat (2) @(negedge clk);
    wr(32'h0000_0005);
    exp_q.push_back(0);
    exp_q.push_back(2);
    pulse_trig();
    man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    chk(mux_sel == 0 && !conv_start && busy, "R9 early done ignored",
        {mux_sel, conv_start, busy}, 1);
    @(negedge clk);
    man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    chk(conv_start && mux_sel == 2, "R5 skip to channel 2", {conv_start, mux_sel}, {1'b1, 5'd2});
    repeat (2) @(negedge clk);
    man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    wait_done("manual R9");

    repeat (3) @(negedge clk);
    summary_and_end();
  end
endmodule